// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of an integrating analog-to-digital converter. It cycles through four phases without pause: a system-zero phase that stores offsets, a fixed-length integration of the unknown input, a de-integration against a reference of opposite polarity, and an integrator-zero phase that returns the integrator to rest. For each phase it drives the matching enables of the analog switch bank.

The comparator output is synchronised and sampled on the last clock of input integration to set the polarity. During de-integration the block counts clocks until the synchronised comparator changes level. That count is the conversion result: the input equals the reference times the count divided by the integration length. If no crossing arrives within a maximum count, an over-range flag is raised and the cycle moves on. A one-clock strobe marks each new result. The result is held until the next strobe.

The run input gates the cycle. When run is low at the end of a cycle, the block parks with every switch open. When run is high in that parked state, a new cycle starts.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `sw_en` is all zeros. `done`, `res_count`, `res_pos` and `res_ovr` are also zero.
- R2: When `run` is low on the last clock of the integrator-zero phase, the block goes idle with `sw_en` = 0 and stays idle while `run` is low. When `run` is high in idle, the system-zero phase begins on the next clock.
- R3: The phases run in the order system zero, input integration, de-integration, integrator zero, and then back to system zero. The `sw_en` bit positions are: bit0 input, bit1 positive reference, bit2 negative reference, bit3 zero, bit4 reference store, bit5 buffer feedback, bit6 integrator zero. The pattern for each phase is: system zero 7'b0111000, input integration 7'b0000001, integrator zero 7'b1100000. De-integration sets bit5 plus exactly one reference bit.
- R4: System zero lasts `SZ_LEN` clocks, input integration lasts `INT_LEN` clocks, and integrator zero lasts `IZ_LEN` clocks.
- R5: The comparator level is passed through two flops and sampled on the last input-integration clock. A high level means a positive input, which selects bit1 during de-integration. A low level selects bit2. `res_pos` reports the sampled level.
- R6: The result counts the de-integration clocks before the crossing is seen. A change of `comp_in` to the opposite level, stable from before the (j+1)th rising edge after de-integration begins, gives `res_count` = j+2 with `res_ovr` = 0.
- R7: If `MAX_DEINT` de-integration clocks pass with no crossing, the result is `res_count` = `MAX_DEINT` with `res_ovr` = 1, and the integrator-zero phase follows. A crossing seen on the final allowed clock takes priority and gives `MAX_DEINT`-1.
- R8: `done` is high for exactly one clock, the first clock of integrator zero. `res_count`, `res_pos` and `res_ovr` change only on that clock and hold their values otherwise.
- R9: When de-integration ends on a crossing, the next clock is integrator zero with `res_ovr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Allows a new measurement cycle to start |
| comp_in | input | 1 | Raw comparator output, high when the integrator is above zero |
| sw_en | output | 7 | Analog switch enables, bit map as in R3 |
| done | output | 1 | One-clock strobe marking a new result |
| res_count | output | CW | De-integration count of the latest conversion |
| res_pos | output | 1 | Polarity of the latest conversion, high for positive |
| res_ovr | output | 1 | Over-range flag of the latest conversion |

## Verification
The checker watches the switch bank on every cycle. It checks that the two reference switches are never closed together and that the input switch is never closed with any other. It checks that `done` is a lone pulse that lands in integrator zero straight after de-integration, that the reported polarity matches the reference switch just used, and that results stay frozen between strobes and within the count bound. Phase lengths, phase order, the j+2 count relation through the synchroniser, the priority at the over-range limit, and the idle behaviour under `run` depend on the comparator stimulus and the clock count, so only the directed scenarios of the bench show them.

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
  parameter int INT_LEN   = 10000,
  parameter int MAX_DEINT = 20000,
  parameter int SZ_LEN    = 100,
  parameter int IZ_LEN    = 100,
  localparam int LA = (INT_LEN > MAX_DEINT) ? INT_LEN : MAX_DEINT,
  localparam int LB = (SZ_LEN > IZ_LEN) ? SZ_LEN : IZ_LEN,
  localparam int CW = $clog2(((LA > LB) ? LA : LB) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          comp_in,
  output logic [6:0]    sw_en,
  output logic          done,
  output logic [CW-1:0] res_count,
  output logic          res_pos,
  output logic          res_ovr
);

  typedef enum logic [2:0] {IDLE, SYSZ, INTG, DEINT, INTZ} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          s1, s2, pol;

  wire crossed = (s2 != pol);

  always_comb begin
    case (phase)
      SYSZ:    sw_en = 7'b0111000;
      INTG:    sw_en = 7'b0000001;
      DEINT:   sw_en = pol ? 7'b0100010 : 7'b0100100;
      INTZ:    sw_en = 7'b1100000;
      default: sw_en = 7'b0000000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= IDLE;
      cnt       <= '0;
      s1        <= 1'b0;
      s2        <= 1'b0;
      pol       <= 1'b0;
      done      <= 1'b0;
      res_count <= '0;
      res_pos   <= 1'b0;
      res_ovr   <= 1'b0;
    end else begin
      s1   <= comp_in;
      s2   <= s1;
      done <= 1'b0;
      case (phase)
        IDLE: begin
          cnt <= '0;
          if (run) phase <= SYSZ;
        end
        SYSZ: begin
          if (cnt == CW'(SZ_LEN - 1)) begin
            cnt   <= '0;
            phase <= INTG;
          end else cnt <= cnt + 1'b1;
        end
        INTG: begin
          if (cnt == CW'(INT_LEN - 1)) begin
            cnt   <= '0;
            pol   <= s2;
            phase <= DEINT;
          end else cnt <= cnt + 1'b1;
        end
        DEINT: begin
          if (crossed || cnt == CW'(MAX_DEINT - 1)) begin
            done      <= 1'b1;
            res_pos   <= pol;
            res_ovr   <= !crossed;
            res_count <= crossed ? cnt : CW'(MAX_DEINT);
            cnt       <= '0;
            phase     <= INTZ;
          end else cnt <= cnt + 1'b1;
        end
        INTZ: begin
          if (cnt == CW'(IZ_LEN - 1)) begin
            cnt   <= '0;
            phase <= run ? SYSZ : IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: phase <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int MAX_DEINT = 20000,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [6:0]    sw_en,
  input logic          done,
  input logic [CW-1:0] res_count,
  input logic          res_pos,
  input logic          res_ovr
);

  p_ref_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_en[1] && sw_en[2]));

  p_in_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en[0] |-> sw_en == 7'b0000001);

  p_pol_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(sw_en[1]) == res_pos && $past(sw_en[2]) == !res_pos);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_count <= CW'(MAX_DEINT));

  p_ovr_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_ovr |-> res_count == CW'(MAX_DEINT));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res_count) && $stable(res_pos) && $stable(res_ovr));

  p_done_iz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sw_en == 7'b1100000 && $past(sw_en[5]) && ($past(sw_en[1]) || $past(sw_en[2])));

endmodule

bind dsadc_seq dsadc_seq_chk #(.MAX_DEINT(MAX_DEINT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .done(done),
  .res_count(res_count), .res_pos(res_pos), .res_ovr(res_ovr)
);

// File: tb/dsadc_seq_test.sv
module dsadc_seq_test;
  localparam int INT_LEN = 20, MAX_DEINT = 40, SZ_LEN = 3, IZ_LEN = 4;
  localparam int CW = 6;
  localparam logic [6:0] SZP = 7'b0111000, INP = 7'b0000001, IZP = 7'b1100000;
  localparam logic [6:0] DPP = 7'b0100010, DPN = 7'b0100100;

  logic clk = 0, rst_n = 0, run = 0, comp_in = 0;
  logic [6:0] sw_en;
  logic done, res_pos, res_ovr;
  logic [CW-1:0] res_count;
  int checks = 0, fails = 0, cyc = 0;

  dsadc_seq #(.INT_LEN(INT_LEN), .MAX_DEINT(MAX_DEINT), .SZ_LEN(SZ_LEN), .IZ_LEN(IZ_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .comp_in(comp_in), .sw_en(sw_en),
    .done(done), .res_count(res_count), .res_pos(res_pos), .res_ovr(res_ovr));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp<=50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pat(input logic [6:0] p);
    for (int n = 0; n < 400 && sw_en != p; n++) @(negedge clk);
  endtask

  task automatic run_conv(input bit pos, input int j, input bit flip,
                          input int exp_cnt, input bit exp_ovr, input string req);
    int n;
    wait_pat(SZP);
    comp_in = pos;
    n = 0;
    while (!(sw_en[5] && (sw_en[1] || sw_en[2])) && n < 400) begin @(negedge clk); n++; end
    chk("R5 ref switch", sw_en, pos ? DPP : DPN);
    if (flip) begin
      repeat (j) @(negedge clk);
      comp_in = !pos;
    end
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk({req, " done"}, done, 1);
    chk({req, " count"}, res_count, exp_cnt);
    chk({req, " ovr"}, res_ovr, exp_ovr);
    chk("R5 res_pos", res_pos, pos);
    chk("R9 IZ after end", sw_en, IZP);
    @(negedge clk);
    chk("R8 single pulse", done, 0);
    comp_in = pos;
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 sw in reset", sw_en, 0);
    chk("R1 done", done, 0);
    chk("R1 count", res_count, 0);
    chk("R1 pos/ovr", {res_pos, res_ovr}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", sw_en, 0);
  endtask

  task automatic t_timing;
    int n;
    repeat (5) @(negedge clk);
    chk("R2 idle while run low", sw_en, 0);
    comp_in = 1;
    run = 1;
    @(negedge clk);
    chk("R2 start SZ", sw_en, SZP);
    n = 0; while (sw_en == SZP && n < 100) begin n++; @(negedge clk); end
    chk("R4 SZ length", n, SZ_LEN);
    chk("R3 SZ->INT", sw_en, INP);
    n = 0; while (sw_en == INP && n < 100) begin n++; @(negedge clk); end
    chk("R4 INT length", n, INT_LEN);
    chk("R3 INT->DEINT", sw_en, DPP);
    comp_in = 0;
    n = 0; while (sw_en == DPP && n < 100) begin n++; @(negedge clk); end
    chk("R3 DEINT->IZ", sw_en, IZP);
    n = 0; while (sw_en == IZP && n < 100) begin n++; @(negedge clk); end
    chk("R4 IZ length", n, IZ_LEN);
    chk("R3 IZ->SZ", sw_en, SZP);
  endtask

  task automatic t_hold;
    logic [CW-1:0] c; logic p, o; int bad = 0, n = 0;
    c = res_count; p = res_pos; o = res_ovr;
    while (!(sw_en[5] && (sw_en[1] || sw_en[2])) && n < 400) begin
      @(negedge clk); n++;
      if (res_count != c || res_pos != p || res_ovr != o) bad++;
    end
    chk("R8 result held", bad, 0);
  endtask

  task automatic t_stop;
    int n = 0;
    wait_pat(IZP);
    run = 0;
    while (sw_en == IZP && n < 100) begin n++; @(negedge clk); end
    for (int k = 0; k < 10; k++) begin
      if (sw_en != 0) n = 1000;
      @(negedge clk);
    end
    chk("R2 stays idle", n, IZ_LEN);
    run = 1;
    @(negedge clk);
    chk("R2 restart SZ", sw_en, SZP);
  endtask

  initial begin
    t_reset;
    t_timing;
    run_conv(1, 5, 1, 7, 0, "R6 positive");
    run_conv(0, 12, 1, 14, 0, "R6 negative");
    run_conv(1, 0, 1, 2, 0, "R6 immediate");
    run_conv(0, 0, 0, MAX_DEINT, 1, "R7 overrange");
    run_conv(1, 37, 1, MAX_DEINT - 1, 0, "R7 crossing at limit");
    t_hold;
    t_stop;
    run_conv(1, 3, 1, 5, 0, "R6 after restart");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule